// File: doc/BRIEF.md
# Interlace-Aware Line Capture Controller

This controller sequences the capture of one video frame, one line at a time, from a sensor's output FIFO into a frame buffer held in memory. On a capture request it latches the frame-buffer base address and the picture settings, then follows the sensor's line counter. For each line it presents a destination address and pulses a start strobe to an external burst mover, then waits for that mover's completion flag before moving to the next line. After the last line it pulses a frame-complete flag.

Two picture sizes are supported: a full size of 640x480 and a quarter size of 320x240, both with 16-bit pixels. At full size the sensor can deliver either progressive lines or two fields, and in the field case the controller weaves them into a progressive frame. It does this by turning each counter value into the right destination line: the first half of the counter range fills the even lines and the second half fills the odd lines. The quarter size always comes from the sensor's field mode, but its lines are stored in counter order without reordering.

Top module: `lcap_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `burst_go` and `frame_done` are 0 and `dst_addr` is 0.
- R2: After a request, no burst is started until `line_cnt` has been seen at 0, even if `line_cnt` already holds some other value.
- R3: Frame step h (h = 0 up to height-1) starts when `line_cnt` equals h. `burst_go` is registered on the clock edge that samples the match and is high for exactly one cycle.
- R4: `dst_addr` equals base + line_index x line_bytes, where line_bytes = width x 2: 1280 at full size and 640 at quarter size.
- R5: At full size with `interlace`=1, counter value h below 240 maps to line_index 2h, and counter value h of 240 or more maps to 2(h-240)+1.
- R6: At full size with `interlace`=0, line_index equals the counter value, and 480 lines are captured.
- R7: With `size_sub`=1, 240 lines of 640 bytes are captured with line_index equal to the counter value, whatever the value of `interlace`.
- R8: After a burst starts, the controller waits for `burst_done`. Until it arrives, no further `burst_go` is issued and `dst_addr` holds its value.
- R9: `frame_done` is a one-cycle pulse. It is visible in the second cycle after `burst_done` is sampled for line height-1, and it stays 0 after every other line.
- R10: A `cap_req` that arrives while a capture is in progress is ignored: the running frame continues with its original base and line order.
- R11: `base_addr`, `size_sub` and `interlace` are sampled only on the cycle a request is accepted. Later changes to them do not affect the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_req | input | 1 | Request to capture one frame |
| size_sub | input | 1 | 1 selects the 320x240 size, 0 the 640x480 size |
| interlace | input | 1 | 1 selects the field-woven order at full size |
| base_addr | input | ADDR_W | Byte address of frame line 0 |
| line_cnt | input | LINE_W | The sensor's current line counter |
| burst_done | input | 1 | The burst mover has finished the current line |
| dst_addr | output | ADDR_W | Destination byte address of the current line |
| burst_go | output | 1 | One-cycle strobe that starts the line transfer |
| frame_done | output | 1 | One-cycle pulse after the last line completes |

## Verification
The hardest case to reach is the second field of a woven full-size frame. Counter values 240 and above must land on odd lines, and the first such line (counter 240, line 1) is reached only after 240 even lines have each completed their full handshake. The bench emulates both the sensor counter and the burst mover, stepping through every counter value of complete frames in each size and mode. For each line it checks the address, the single-cycle strobe, the hold while completion is withheld, and the placement of the frame pulse. The stray-request and input-change cases are injected in the middle of a running frame, and their effect is checked against the addresses of the lines that follow.

// File: rtl/lcap_pkg.sv
package lcap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SYNC  = 3'd1,
    ST_ARM   = 3'd2,
    ST_MOVE  = 3'd3,
    ST_CLEAR = 3'd4
  } lcap_state_t;
endpackage

// File: rtl/lcap_line_map.sv
module lcap_line_map #(
  parameter int LINE_W = 9,
  parameter int HALF   = 240
) (
  input  logic [LINE_W-1:0] cnt,
  input  logic              weave,
  output logic [LINE_W-1:0] idx
);
  always_comb begin
    if (!weave)
      idx = cnt;
    else if (cnt < LINE_W'(HALF))
      idx = LINE_W'({cnt, 1'b0});
    else
      idx = LINE_W'({LINE_W'(cnt - LINE_W'(HALF)), 1'b1});
  end
endmodule

// File: rtl/lcap_addr.sv
module lcap_addr #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 9,
  parameter int LB_W   = 11
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [LINE_W-1:0] idx,
  input  logic [LB_W-1:0]   line_bytes,
  output logic [ADDR_W-1:0] addr
);
  always_comb addr = base + ADDR_W'(idx) * ADDR_W'(line_bytes);
endmodule

// File: rtl/lcap_seq.sv
module lcap_seq
  import lcap_pkg::*;
#(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_req,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [LINE_W-1:0] last_line,
  input  logic              burst_done,
  output logic              start,
  output logic              load,
  output logic              busy,
  output logic [LINE_W-1:0] cur_line,
  output logic              frame_done
);
  lcap_state_t st;

  assign start = (st == ST_IDLE) && cap_req;
  assign load  = (st == ST_ARM) && (line_cnt == cur_line);
  assign busy  = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur_line   <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      unique case (st)
        ST_IDLE: if (cap_req) begin
          st       <= ST_SYNC;
          cur_line <= '0;
        end
        ST_SYNC:  if (line_cnt == '0) st <= ST_ARM;
        ST_ARM:   if (line_cnt == cur_line) st <= ST_MOVE;
        ST_MOVE:  if (burst_done) st <= ST_CLEAR;
        ST_CLEAR: begin
          if (cur_line == last_line) begin
            st         <= ST_IDLE;
            frame_done <= 1'b1;
          end else begin
            cur_line <= cur_line + 1'b1;
            st       <= ST_ARM;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MOVE && !burst_done) |=> (st == ST_MOVE)); // R8

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && st != ST_SYNC && cap_req) |=> (st != ST_SYNC)); // R10

  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (st == ST_IDLE && cur_line == last_line)); // R9
endmodule

// File: rtl/lcap_ctrl.sv
module lcap_ctrl #(
  parameter int FULL_W    = 640,
  parameter int FULL_H    = 480,
  parameter int PIX_BYTES = 2,
  parameter int ADDR_W    = 32,
  parameter int LINE_W    = $clog2(FULL_H)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_req,
  input  logic              size_sub,
  input  logic              interlace,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              burst_done,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              burst_go,
  output logic              frame_done
);
  localparam int SUB_W = FULL_W / 2;
  localparam int SUB_H = FULL_H / 2;
  localparam int LB_W  = $clog2(FULL_W * PIX_BYTES + 1);

  logic [ADDR_W-1:0] base_q;
  logic              sub_q;
  logic              weave_q;
  logic [LINE_W-1:0] last_line;
  logic [LB_W-1:0]   line_bytes;
  logic              start, load, busy;
  logic [LINE_W-1:0] cur_line, line_idx;
  logic [ADDR_W-1:0] next_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      sub_q   <= 1'b0;
      weave_q <= 1'b0;
    end else if (start) begin
      base_q  <= base_addr;
      sub_q   <= size_sub;
      weave_q <= interlace && !size_sub;
    end
  end

  assign last_line  = sub_q ? LINE_W'(SUB_H - 1) : LINE_W'(FULL_H - 1);
  assign line_bytes = sub_q ? LB_W'(SUB_W * PIX_BYTES) : LB_W'(FULL_W * PIX_BYTES);

  lcap_seq #(.LINE_W(LINE_W)) seq_i (
    .clk(clk), .rst(rst), .cap_req(cap_req), .line_cnt(line_cnt),
    .last_line(last_line), .burst_done(burst_done), .start(start),
    .load(load), .busy(busy), .cur_line(cur_line), .frame_done(frame_done)
  );

  lcap_line_map #(.LINE_W(LINE_W), .HALF(SUB_H)) map_i (
    .cnt(cur_line), .weave(weave_q), .idx(line_idx)
  );

  lcap_addr #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .LB_W(LB_W)) addr_i (
    .base(base_q), .idx(line_idx), .line_bytes(line_bytes), .addr(next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_addr <= '0;
      burst_go <= 1'b0;
    end else begin
      burst_go <= load;
      if (load) dst_addr <= next_addr;
    end
  end

  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    burst_go |=> !burst_go); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    burst_go |=> $stable(dst_addr)); // R8

  AST_BASE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (busy && cap_req) |=> $stable(base_q)); // R10
endmodule

// File: tb/lcap_ctrl_tb_top.sv
module lcap_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_req = 1'b0;
  logic        size_sub = 1'b0;
  logic        interlace = 1'b0;
  logic [31:0] base_addr = '0;
  logic [8:0]  line_cnt = '0;
  logic        burst_done = 1'b0;
  logic [31:0] dst_addr;
  logic        burst_go;
  logic        frame_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  lcap_ctrl dut_i (
    .clk(clk), .rst(rst), .cap_req(cap_req), .size_sub(size_sub),
    .interlace(interlace), .base_addr(base_addr), .line_cnt(line_cnt),
    .burst_done(burst_done), .dst_addr(dst_addr), .burst_go(burst_go),
    .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(burst_go == 0 && frame_done == 0 && dst_addr == 0, "R1 in reset", {burst_go, frame_done, dst_addr}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(burst_go == 0 && frame_done == 0 && dst_addr == 0, "R1 after reset", {burst_go, frame_done, dst_addr}, 0);
  endtask

  // Full frame: emulates sensor counter and burst mover.
  task automatic run_frame(input bit qv, input bit il, input logic [31:0] base,
                           input int pre, input bit poke, input string tag);
    int lines = qv ? 240 : 480;
    int lb    = qv ? 640 : 1280;
    @(negedge clk);
    line_cnt  = 9'(pre);
    size_sub  = qv;
    interlace = il;
    base_addr = base;
    cap_req   = 1'b1;
    @(negedge clk);
    cap_req   = 1'b0;
    // R11: scramble settings after acceptance
    size_sub  = !qv;
    interlace = !il;
    base_addr = base ^ 32'h00F0_0000;
    if (pre != 0) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(burst_go == 0, "R2 no burst before counter 0", burst_go, 0);
      end
    end
    for (int h = 0; h < lines; h++) begin
      int idx;
      int w;
      logic [31:0] exp_a;
      logic [31:0] held;
      if (poke && h == 10) begin
        cap_req   = 1'b1;
        base_addr = 32'h7777_0000;
        @(negedge clk);
        cap_req   = 1'b0;
        chk(burst_go == 0, "R10 stray request no burst", burst_go, 0);
      end
      line_cnt = 9'(h);
      if (!qv && il) idx = (h < 240) ? 2 * h : 2 * (h - 240) + 1;
      else idx = h;
      exp_a = base + 32'(idx * lb);
      w = 0;
      while (!burst_go && w < 20) begin
        @(negedge clk);
        w++;
      end
      chk(burst_go == 1 && dst_addr == exp_a, tag, {31'(burst_go), dst_addr}, {32'd1, exp_a});
      held = dst_addr;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk(burst_go == 0 && dst_addr == held, "R8 wait for done", {31'(burst_go), dst_addr}, {32'd0, held});
      end
      burst_done = 1'b1;
      @(negedge clk);
      burst_done = 1'b0;
      @(negedge clk);
      chk(frame_done == (h == lines - 1), "R9 frame_done placement", frame_done, (h == lines - 1));
    end
    @(negedge clk);
    chk(frame_done == 0, "R9 frame_done single cycle", frame_done, 0);
    chk(burst_go == 0, "R9 idle after frame", burst_go, 0);
  endtask

  task automatic t_vga_woven;
    run_frame(1'b0, 1'b1, 32'h1000_0000, 7, 1'b0, "R5 R4 woven address");
  endtask

  task automatic t_vga_progressive;
    run_frame(1'b0, 1'b0, 32'h2000_0100, 0, 1'b0, "R6 R3 progressive address");
  endtask

  task automatic t_sub_size;
    run_frame(1'b1, 1'b0, 32'h0004_0000, 3, 1'b0, "R7 sub-size address");
    run_frame(1'b1, 1'b1, 32'h0008_0000, 0, 1'b0, "R7 sub-size ignores interlace");
  endtask

  task automatic t_busy_request;
    run_frame(1'b0, 1'b1, 32'h3000_0000, 0, 1'b1, "R10 R11 address unaffected");
  endtask

  initial begin
    t_reset();
    t_vga_woven();
    t_vga_progressive();
    t_sub_size();
    t_busy_request();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule